// File: doc/BRIEF.md
# Radio Packet Transmit Byte Sequencer

This block supplies, one byte at a time, the complete on-air byte stream of one outgoing radio packet. A host first writes up to 66 payload bytes into the internal payload store, places the network group, header and payload length on its inputs, and pulses `start`. From then on the transceiver pulls bytes: every `byte_req` strobe produces exactly one byte on `tx_byte` with `tx_valid` high in the following cycle. Nothing is emitted on a timer.

The stream is three fill bytes of 0xAA, the sync byte 0x2D, the group byte, the header, the length byte, the payload bytes, the two bytes of a running CRC-16 (low byte first), and two trailing 0xAA bytes. The CRC is the reflected CRC-16 (constant 0xA001, LSB first, preset 0xFFFF) and covers the group byte, the header as sent, the length byte and the payload. With the last trailing byte the block pulses `idle_cmd` so that the radio can be returned to idle.

The controller is one state machine with states ST_IDLE, ST_PREAMBLE, ST_SYNC, ST_GROUP, ST_HEADER, ST_LENGTH, ST_PAYLOAD, ST_CRC_LO, ST_CRC_HI and ST_TAIL. Transitions: ST_IDLE to ST_PREAMBLE on `start`; every other transition happens on `byte_req`: ST_PREAMBLE to ST_SYNC after its third byte, ST_SYNC to ST_GROUP, ST_GROUP to ST_HEADER, ST_HEADER to ST_LENGTH, ST_LENGTH to ST_PAYLOAD (or to ST_CRC_LO when the length is zero), ST_PAYLOAD to ST_CRC_LO after the last payload byte, ST_CRC_LO to ST_CRC_HI, ST_CRC_HI to ST_TAIL, and ST_TAIL to ST_IDLE after its second byte.

Top module: `pkt_tx_seq`

## Requirements
- R1: A byte appears (`tx_valid` high for one cycle, `tx_byte` valid) only in the cycle after a `byte_req` strobe taken while `busy` is high; a `byte_req` while `busy` is low produces no byte.
- R2: The first three bytes of a packet are 0xAA, the fourth is the sync byte 0x2D, the fifth is the group byte.
- R3: After the group byte come the header, then the length byte, then exactly that many payload bytes in payload-store address order starting at address 0.
- R4: If header bit 6 (value 0x40) is clear, header bits 4:0 are replaced by the 5-bit `node_id` and bits 7:5 are kept; if bit 6 is set the header is sent unchanged.
- R5: The CRC is reflected CRC-16 with constant 0xA001 processed LSB first, preset to 0xFFFF, updated with the group, the header as sent, the length byte and each payload byte; its low byte is sent before its high byte.
- R6: Two 0xAA bytes follow the CRC; `idle_cmd` is high in exactly the cycle the second of them is presented and in no other cycle.
- R7: `busy` is high from the cycle after an accepted `start` until the cycle `idle_cmd` is high, in which it is low; a `start` while `busy` is high has no effect, and group, header, length and `node_id` are sampled at the accepted `start`.
- R8: With a length of zero the CRC low byte directly follows the length byte.
- R9: A length input above 66 is treated as 66: the length byte sent is 66 and 66 payload bytes follow.
- R10: After reset `busy`, `tx_valid` and `idle_cmd` are low.
- R11: A `byte_req` in the same cycle as an accepted `start` is ignored: no byte follows it, and the packet still begins with its full three-byte preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| node_id | input | 5 | Local node ID inserted into non-addressed headers |
| grp_in | input | 8 | Network group byte |
| hdr_in | input | 8 | Header byte (bit 6 = destination flag) |
| len_in | input | 8 | Payload length, clamped to 66 |
| wr_en | input | 1 | Payload store write enable |
| wr_addr | input | 7 | Payload store write address |
| wr_data | input | 8 | Payload store write data |
| start | input | 1 | Begin a packet (accepted only when idle) |
| byte_req | input | 1 | Transceiver byte-request strobe |
| tx_byte | output | 8 | Outgoing byte |
| tx_valid | output | 1 | `tx_byte` carries a new byte this cycle |
| idle_cmd | output | 1 | Pulse: return the radio to idle |
| busy | output | 1 | A packet is in progress |

## Verification
Two functions can meet in one cycle: acceptance of `start` and the byte-request path, both at the front of a packet (a `byte_req` together with `start`) and in the middle of a packet (a `start` arriving while bytes are being pulled). The sweep drives `byte_req` in the very cycle of `start` on some packets and pulses `start` with altered inputs after the header on others. It judges both by the byte stream: no byte may follow the colliding request, and the entire packet, including the three preamble bytes and the CRC, must still match the frame computed in the bench from the values present at the accepted `start`.

// File: rtl/pkt_tx_pkg.sv
`timescale 1ns/1ps
package pkt_tx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_SYNC,
        ST_GROUP,
        ST_HEADER,
        ST_LENGTH,
        ST_PAYLOAD,
        ST_CRC_LO,
        ST_CRC_HI,
        ST_TAIL
    } seq_state_e;

    localparam logic [15:0] CRC_POLY = 16'hA001;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    // One byte of the reflected CRC-16, LSB first.
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {8'h00, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/pkt_tx_buf.sv
`timescale 1ns/1ps
module pkt_tx_buf #(
    parameter int DEPTH = 66,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_addr) < DEPTH)) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : 8'h00;
endmodule

// File: rtl/pkt_tx_crc.sv
`timescale 1ns/1ps
module pkt_tx_crc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        seed_en,
    input  logic        upd_en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    import pkt_tx_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= CRC_SEED;
        end else if (seed_en) begin
            crc <= crc16_step(CRC_SEED, din);
        end else if (upd_en) begin
            crc <= crc16_step(crc, din);
        end
    end
endmodule

// File: rtl/pkt_tx_seq.sv
`timescale 1ns/1ps
module pkt_tx_seq #(
    parameter int          MAX_LEN   = 66,
    parameter int          PRE_N     = 3,
    parameter int          TAIL_N    = 2,
    parameter int          ID_W      = 5,
    parameter logic [7:0]  SYNC_BYTE = 8'h2D,
    parameter logic [7:0]  FILL_BYTE = 8'hAA,
    parameter int          AW        = $clog2(MAX_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] node_id,
    input  logic [7:0]      grp_in,
    input  logic [7:0]      hdr_in,
    input  logic [7:0]      len_in,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [7:0]      wr_data,
    input  logic            start,
    input  logic            byte_req,
    output logic [7:0]      tx_byte,
    output logic            tx_valid,
    output logic            idle_cmd,
    output logic            busy
);
    import pkt_tx_pkg::*;

    localparam int LEN_W = $clog2(MAX_LEN + 1);
    localparam logic [LEN_W-1:0] PRE_LAST  = LEN_W'(PRE_N - 1);
    localparam logic [LEN_W-1:0] TAIL_LAST = LEN_W'(TAIL_N - 1);
    localparam logic [LEN_W-1:0] LEN_CAP   = LEN_W'(MAX_LEN);
    localparam int DST_BIT = 6;

    seq_state_e       state_q, state_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic [LEN_W-1:0] len_q;
    logic [7:0]       grp_q, hdr_q;
    logic [7:0]       cur_byte, pay_byte;
    logic [15:0]      crc;
    logic             launch, take, last, crc_upd;
    logic [LEN_W-1:0] len_clamped;
    logic [7:0]       hdr_eff;

    assign launch = start && (state_q == ST_IDLE);
    assign take   = byte_req && (state_q != ST_IDLE);
    assign busy   = (state_q != ST_IDLE);

    assign len_clamped = (int'(len_in) > MAX_LEN) ? LEN_CAP : len_in[LEN_W-1:0];
    assign hdr_eff     = hdr_in[DST_BIT] ? hdr_in : {hdr_in[7:ID_W], node_id};

    pkt_tx_buf #(.DEPTH(MAX_LEN), .AW(AW)) buf_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (AW'(cnt_q)),
        .rd_data (pay_byte)
    );

    assign crc_upd = take && ((state_q == ST_HEADER) || (state_q == ST_LENGTH) ||
                              (state_q == ST_PAYLOAD));

    pkt_tx_crc crc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .seed_en (launch),
        .upd_en  (crc_upd),
        .din     (launch ? grp_in : cur_byte),
        .crc     (crc)
    );

    // Byte for the current state
    always_comb begin
        unique case (state_q)
            ST_PREAMBLE: cur_byte = FILL_BYTE;
            ST_SYNC:     cur_byte = SYNC_BYTE;
            ST_GROUP:    cur_byte = grp_q;
            ST_HEADER:   cur_byte = hdr_q;
            ST_LENGTH:   cur_byte = 8'(len_q);
            ST_PAYLOAD:  cur_byte = pay_byte;
            ST_CRC_LO:   cur_byte = crc[7:0];
            ST_CRC_HI:   cur_byte = crc[15:8];
            ST_TAIL:     cur_byte = FILL_BYTE;
            default:     cur_byte = 8'h00;
        endcase
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        last    = 1'b0;
        if (launch) begin
            state_d = ST_PREAMBLE;
            cnt_d   = '0;
        end else if (take) begin
            unique case (state_q)
                ST_PREAMBLE: begin
                    if (cnt_q == PRE_LAST) begin
                        state_d = ST_SYNC;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_SYNC:   state_d = ST_GROUP;
                ST_GROUP:  state_d = ST_HEADER;
                ST_HEADER: state_d = ST_LENGTH;
                ST_LENGTH: begin
                    state_d = (len_q == '0) ? ST_CRC_LO : ST_PAYLOAD;
                    cnt_d   = '0;
                end
                ST_PAYLOAD: begin
                    if (cnt_q == len_q - 1'b1) begin
                        state_d = ST_CRC_LO;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_CRC_LO: state_d = ST_CRC_HI;
                ST_CRC_HI: begin
                    state_d = ST_TAIL;
                    cnt_d   = '0;
                end
                ST_TAIL: begin
                    if (cnt_q == TAIL_LAST) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                        last    = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // State register and packet fields captured at start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            grp_q   <= '0;
            hdr_q   <= '0;
            len_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (launch) begin
                grp_q <= grp_in;
                hdr_q <= hdr_eff;
                len_q <= len_clamped;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_byte  <= '0;
            tx_valid <= 1'b0;
            idle_cmd <= 1'b0;
        end else begin
            tx_valid <= take;
            idle_cmd <= last;
            if (take) begin
                tx_byte <= cur_byte;
            end
        end
    end
endmodule

// File: rtl/pkt_tx_seq_chk.sv
`timescale 1ns/1ps
module pkt_tx_seq_chk #(
    parameter logic [7:0] FILL_BYTE = 8'hAA
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       byte_req,
    input logic [7:0] tx_byte,
    input logic       tx_valid,
    input logic       idle_cmd,
    input logic       busy
);
    // R1
    byte_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(byte_req));

    // R1
    idle_req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req && !busy) |=> !tx_valid);

    // R6
    tail_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cmd |-> (tx_valid && tx_byte == FILL_BYTE));

    // R7
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cmd |-> !busy);

    // R7
    hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !byte_req) |=> busy);

    // R7
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

bind pkt_tx_seq pkt_tx_seq_chk #(.FILL_BYTE(FILL_BYTE)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .byte_req (byte_req),
    .tx_byte  (tx_byte),
    .tx_valid (tx_valid),
    .idle_cmd (idle_cmd),
    .busy     (busy)
);

// File: tb/pkt_tx_seq_tb_top.sv
`timescale 1ns/1ps
module pkt_tx_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] node_id;
    logic [7:0] grp_in, hdr_in, len_in;
    logic       wr_en;
    logic [6:0] wr_addr;
    logic [7:0] wr_data;
    logic       start, byte_req;
    logic [7:0] tx_byte;
    logic       tx_valid, idle_cmd, busy;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    pkt_tx_seq dut_i (
        .clk(clk), .rst_n(rst_n), .node_id(node_id), .grp_in(grp_in),
        .hdr_in(hdr_in), .len_in(len_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start(start), .byte_req(byte_req),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .idle_cmd(idle_cmd), .busy(busy)
    );

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb = r[0] ^ d[i];
            r = r >> 1;
            if (fb) r = r ^ 16'hA001;
        end
        return r;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic pull(input string req, input logic [7:0] exp, input bit last);
        @(negedge clk) byte_req = 1'b1;
        @(negedge clk) byte_req = 1'b0;
        chk("R1", "tx_valid", tx_valid, 1);
        chk(req, "tx_byte", tx_byte, exp);
        chk("R6", "idle_cmd", idle_cmd, last);
    endtask

    task automatic run_packet(input int len, input logic [7:0] hdr, input logic [4:0] nid,
                              input logic [7:0] grp, input bit poke, input bit collide);
        logic [7:0] pay [66];
        logic [7:0] hexp;
        logic [15:0] crc;
        int eff = (len > 66) ? 66 : len;
        for (int i = 0; i < 66; i++) begin
            pay[i] = 8'(i * 37 + len * 11 + 5);
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 7'(i); wr_data = pay[i];
        end
        @(negedge clk) wr_en = 1'b0;
        node_id = nid; grp_in = grp; hdr_in = hdr; len_in = 8'(len);
        start = 1'b1; byte_req = collide;
        @(negedge clk) start = 1'b0; byte_req = 1'b0;
        chk("R7", "busy after start", busy, 1);
        // R11: request in the start cycle yields no byte
        if (collide) chk("R11", "tx_valid on colliding request", tx_valid, 0);
        // disturb the inputs: values were sampled at start (R7)
        node_id = ~nid; grp_in = ~grp; hdr_in = ~hdr; len_in = 8'(len + 3);
        hexp = hdr[6] ? hdr : {hdr[7:5], nid};
        crc = ref_crc(16'hFFFF, grp);
        for (int i = 0; i < 3; i++) pull("R2", 8'hAA, 0);
        pull("R2", 8'h2D, 0);
        pull("R2", grp, 0);
        pull("R4", hexp, 0);
        crc = ref_crc(crc, hexp);
        if (poke) begin
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
            chk("R7", "busy after ignored start", busy, 1);
        end
        pull((len > 66) ? "R9" : "R3", 8'(eff), 0);
        crc = ref_crc(crc, 8'(eff));
        for (int i = 0; i < eff; i++) begin
            pull((len > 66) ? "R9" : "R3", pay[i], 0);
            crc = ref_crc(crc, pay[i]);
        end
        pull((eff == 0) ? "R8" : "R5", crc[7:0], 0);
        pull("R5", crc[15:8], 0);
        pull("R6", 8'hAA, 0);
        chk("R7", "busy before last tail", busy, 1);
        pull("R6", 8'hAA, 1);
        chk("R7", "busy with idle_cmd", busy, 0);
        @(negedge clk) byte_req = 1'b1;
        @(negedge clk) byte_req = 1'b0;
        chk("R1", "tx_valid after packet", tx_valid, 0);
    endtask

    initial begin
        rst_n = 1'b0; node_id = '0; grp_in = '0; hdr_in = '0; len_in = '0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; start = 1'b0; byte_req = 1'b0;
        repeat (3) @(negedge clk);
        // R10
        chk("R10", "busy", busy, 0);
        chk("R10", "tx_valid", tx_valid, 0);
        chk("R10", "idle_cmd", idle_cmd, 0);
        rst_n = 1'b1;
        @(negedge clk) byte_req = 1'b1;
        @(negedge clk) byte_req = 1'b0;
        chk("R1", "tx_valid when idle", tx_valid, 0);
        for (int l = 0; l <= 66; l++) begin
            logic [7:0] h = 8'(l * 29 + 3);
            h[6] = l[0];
            run_packet(l, h, 5'(l % 32), 8'(l * 3), (l % 5) == 2, (l % 7) == 3);
        end
        run_packet(67, 8'h15, 5'd31, 8'h2D, 1'b1, 1'b1);
        run_packet(70, 8'h9F, 5'd0, 8'hFF, 1'b0, 1'b0);
        run_packet(255, 8'h40, 5'd17, 8'h00, 1'b1, 1'b0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule